// File: doc/BRIEF.md
# Speculative Thread Order Sequencer

This block keeps the program order of speculative loop iterations that run one per core on a small group of cores (four by default). Each core holds one iteration. The cores form a rotating ring. The core that holds the oldest iteration is the head and is the only one that is not speculative. Moving away from the head, each core holds a later iteration with a higher rank. Every core reports when it begins its iteration (start), when it has finished (done), and when a read it made turned out to be too early (violation). The sequencer returns each core's rank, marks the head, issues commit grants and issues restart commands. Cache and write-buffer logic downstream acts on those grants and commands.

Commit goes strictly in order. Only a finished head may retire, and it retires on the edge after its finished state is recorded. The head then passes to the next core in the ring. The retired core becomes the youngest rank and waits to start a new iteration. A core that finishes early holds its finished state until it becomes the head. A violation from a running or finished core restarts that core and every younger core in one step, so their buffered writes can be thrown away. The head cannot be restarted.

Top module: `spec_thread_sequencer`

## Requirements
- R1: After reset, core 0 is the head (head_o = 0001), core c has rank c (rank_o = 8'hE4 for four cores), no commit or restart is asserted, and every core waits for start.
- R2: The rank of core c is always (c - h) mod NCORES, where h is the head index. rank_o carries core c's rank in bits [c*RW +: RW]. head_o is one-hot on the head core.
- R3: If the head core's done is sampled while it is running, its commit_o bit is high for exactly one cycle, following the second clock edge after that sampling.
- R4: A non-head core that finishes gets no commit while it is not the head. Once it becomes the head while finished, it commits on the next edge, so a run of finished cores retires one per cycle.
- R5: At most one commit_o bit is high in any cycle, and it belongs to the core that was head before that edge.
- R6: On a commit, the head moves one core forward in the ring and the retired core takes rank NCORES-1. Without a commit, the head does not move.
- R7: A violation sampled from a core that is running or finished, and is not the head, raises restart_o for one cycle after that edge. It is raised for that core and for every core of higher rank, and for no other core.
- R8: If several cores report qualifying violations at the same edge, the restart group starts at the violator with the lowest rank.
- R9: A violation from the head, or from a core that is waiting for start, is ignored: no restart results.
- R10: A restarted or retired core waits for start. A done seen while waiting is ignored and cannot lead to a commit. Start is needed before done counts.
- R11: A core counts only the input that fits its state: start only while waiting, done only while running. A core that is running or finished goes back to waiting only through a commit or a restart.
- R12: If a commit and a violation land on the same edge, the head still commits, and the restart group is chosen using the ranks from before that edge. Commit and restart never hit the same core in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | NCORES | Per-core: iteration execution has begun |
| done_i | input | NCORES | Per-core: iteration has finished |
| viol_i | input | NCORES | Per-core: a dependency violation was detected |
| rank_o | output | NCORES*RW | Per-core program-order rank, 0 = head |
| head_o | output | NCORES | One-hot head (non-speculative) core |
| commit_o | output | NCORES | One-cycle commit grant |
| restart_o | output | NCORES | One-cycle squash-and-restart command |

## Verification
The assertions assume only that reset is held for at least one clock edge and that the inputs are stable around each edge. They make no assumption about the inputs themselves being legal. Start, done and violation may come in any combination, at any time, from any core, because the sequencer itself filters out what does not fit a core's state. The stimulus relies on this. Its directed cases deliberately send done to waiting cores, violations from the head and from waiting cores, and a commit together with a squash on the same edge. A long random sweep then drives arbitrary vectors against an arithmetic rank model.

// File: rtl/spec_seq_pkg.sv
package spec_seq_pkg;

   typedef enum logic [1:0] {
      SLOT_WAIT = 2'd0,
      SLOT_RUN  = 2'd1,
      SLOT_FIN  = 2'd2
   } slot_state_e;

endpackage

// File: rtl/spec_order_ring.sv
module spec_order_ring #(
   parameter int NCORES   = 4,
   parameter bit RANK_REG = 1'b1,
   localparam int RW      = $clog2(NCORES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 advance_i,
   output logic [NCORES-1:0]    head_oh_o,
   output logic [NCORES*RW-1:0] rank_flat_o
);

   if (NCORES < 2) begin : g_bad_small
      $error("spec_order_ring: NCORES must be at least 2");
   end
   if ((1 << RW) != NCORES) begin : g_bad_pow2
      $error("spec_order_ring: NCORES must be a power of two");
   end

   logic [RW-1:0] head_q;
   logic [RW-1:0] head_nx;

   assign head_nx = advance_i ? head_q + RW'(1) : head_q;

   always_ff @(posedge clk) begin
      if (!rst_n) head_q <= '0;
      else        head_q <= head_nx;
   end

   for (genvar c = 0; c < NCORES; c++) begin : g_core
      assign head_oh_o[c] = (head_q == RW'(c));

      if (RANK_REG) begin : g_reg
         logic [RW-1:0] rank_q;
         always_ff @(posedge clk) begin
            if (!rst_n) rank_q <= RW'(c);
            else        rank_q <= RW'(c) - head_nx;
         end
         assign rank_flat_o[c*RW +: RW] = rank_q;
      end else begin : g_comb
         assign rank_flat_o[c*RW +: RW] = RW'(c) - head_q;
      end
   end

endmodule

// File: rtl/spec_squash_select.sv
module spec_squash_select #(
   parameter int NCORES = 4,
   localparam int RW    = $clog2(NCORES)
) (
   input  logic [NCORES-1:0]    viol_ok_i,
   input  logic [NCORES*RW-1:0] rank_flat_i,
   output logic [NCORES-1:0]    squash_o
);

   logic          found;
   logic [RW-1:0] min_rank;

   always_comb begin
      found    = 1'b0;
      min_rank = '1;
      for (int c = 0; c < NCORES; c++) begin
         if (viol_ok_i[c] && (!found || rank_flat_i[c*RW +: RW] < min_rank)) begin
            found    = 1'b1;
            min_rank = rank_flat_i[c*RW +: RW];
         end
      end
   end

   for (genvar c = 0; c < NCORES; c++) begin : g_mask
      assign squash_o[c] = found && (rank_flat_i[c*RW +: RW] >= min_rank);
   end

endmodule

// File: rtl/spec_core_slot.sv
module spec_core_slot
   import spec_seq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic done_i,
   input  logic squash_i,
   input  logic retire_i,
   output logic live_o,
   output logic fin_o,
   output logic commit_o,
   output logic restart_o
);

   slot_state_e state_q;
   logic        commit_q;
   logic        restart_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= SLOT_WAIT;
         commit_q  <= 1'b0;
         restart_q <= 1'b0;
      end else begin
         commit_q  <= retire_i;
         restart_q <= squash_i;
         if (retire_i || squash_i) begin
            state_q <= SLOT_WAIT;
         end else begin
            unique case (state_q)
               SLOT_WAIT: if (start_i) state_q <= SLOT_RUN;
               SLOT_RUN:  if (done_i)  state_q <= SLOT_FIN;
               SLOT_FIN:  state_q <= SLOT_FIN;
               default:   state_q <= SLOT_WAIT;
            endcase
         end
      end
   end

   assign live_o    = (state_q == SLOT_RUN) || (state_q == SLOT_FIN);
   assign fin_o     = (state_q == SLOT_FIN);
   assign commit_o  = commit_q;
   assign restart_o = restart_q;

endmodule

// File: rtl/spec_thread_sequencer.sv
module spec_thread_sequencer #(
   parameter int NCORES   = 4,
   parameter bit RANK_REG = 1'b1,
   localparam int RW      = $clog2(NCORES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NCORES-1:0]    start_i,
   input  logic [NCORES-1:0]    done_i,
   input  logic [NCORES-1:0]    viol_i,
   output logic [NCORES*RW-1:0] rank_o,
   output logic [NCORES-1:0]    head_o,
   output logic [NCORES-1:0]    commit_o,
   output logic [NCORES-1:0]    restart_o
);

   logic [NCORES-1:0] head_oh;
   logic [NCORES-1:0] live;
   logic [NCORES-1:0] fin;
   logic [NCORES-1:0] viol_ok;
   logic [NCORES-1:0] squash;
   logic [NCORES-1:0] retire;
   logic              head_fin;

   assign head_fin = |(fin & head_oh);
   assign retire   = head_oh & {NCORES{head_fin}};
   assign viol_ok  = viol_i & live & ~head_oh;

   spec_order_ring #(
      .NCORES   (NCORES),
      .RANK_REG (RANK_REG)
   ) u_ring (
      .clk         (clk),
      .rst_n       (rst_n),
      .advance_i   (head_fin),
      .head_oh_o   (head_oh),
      .rank_flat_o (rank_o)
   );

   spec_squash_select #(
      .NCORES (NCORES)
   ) u_squash (
      .viol_ok_i   (viol_ok),
      .rank_flat_i (rank_o),
      .squash_o    (squash)
   );

   for (genvar c = 0; c < NCORES; c++) begin : g_slot
      spec_core_slot u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .start_i   (start_i[c]),
         .done_i    (done_i[c]),
         .squash_i  (squash[c]),
         .retire_i  (retire[c]),
         .live_o    (live[c]),
         .fin_o     (fin[c]),
         .commit_o  (commit_o[c]),
         .restart_o (restart_o[c])
      );
   end

   assign head_o = head_oh;

endmodule

// File: rtl/spec_thread_sequencer_chk.sv
module spec_thread_sequencer_chk #(
   parameter int NCORES   = 4,
   parameter bit RANK_REG = 1'b1,
   localparam int RW      = $clog2(NCORES)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NCORES-1:0]    start_i,
   input logic [NCORES-1:0]    done_i,
   input logic [NCORES-1:0]    viol_i,
   input logic [NCORES*RW-1:0] rank_o,
   input logic [NCORES-1:0]    head_o,
   input logic [NCORES-1:0]    commit_o,
   input logic [NCORES-1:0]    restart_o
);

   logic [NCORES*RW-1:0] rank_prev;
   logic [NCORES-1:0]    head_prev;
   logic                 suffix_ok;
   logic                 perm_ok;
   logic [NCORES-1:0]    seen;
   logic                 unused_in;

   assign unused_in = RANK_REG ^ (|start_i) ^ (|done_i) ^ (|viol_i);

   always_ff @(posedge clk) begin
      rank_prev <= rank_o;
      head_prev <= head_o;
   end

   always_comb begin
      suffix_ok = 1'b1;
      for (int c = 0; c < NCORES; c++) begin
         for (int d = 0; d < NCORES; d++) begin
            if (restart_o[c] && rank_prev[d*RW +: RW] > rank_prev[c*RW +: RW] && !restart_o[d])
               suffix_ok = 1'b0;
         end
      end
   end

   always_comb begin
      seen = '0;
      for (int c = 0; c < NCORES; c++) seen[rank_o[c*RW +: RW]] = 1'b1;
      perm_ok = &seen;
   end

   p_one_head_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(head_o) == 1);

   p_rank_perm_r2: assert property (@(posedge clk) disable iff (!rst_n)
      perm_ok);

   p_commit_from_head_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (|commit_o) |-> ($countones(commit_o) == 1 && (commit_o & head_prev) == commit_o));

   p_head_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|commit_o) |-> (head_o == {head_prev[NCORES-2:0], head_prev[NCORES-1]}));

   p_head_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(|commit_o) |-> (head_o == head_prev));

   p_restart_suffix_r7: assert property (@(posedge clk) disable iff (!rst_n)
      suffix_ok);

   p_no_head_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (restart_o & head_prev) == '0);

   p_disjoint_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_o & restart_o) == '0);

   for (genvar c = 0; c < NCORES; c++) begin : g_young
      p_retired_youngest_r6: assert property (@(posedge clk) disable iff (!rst_n)
         commit_o[c] |-> (rank_o[c*RW +: RW] == RW'(NCORES - 1)));
   end

endmodule

bind spec_thread_sequencer spec_thread_sequencer_chk #(
   .NCORES   (NCORES),
   .RANK_REG (RANK_REG)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .done_i    (done_i),
   .viol_i    (viol_i),
   .rank_o    (rank_o),
   .head_o    (head_o),
   .commit_o  (commit_o),
   .restart_o (restart_o)
);

// File: tb/spec_thread_sequencer_tb.sv
module spec_thread_sequencer_tb;

   localparam int N  = 4;
   localparam int RW = 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [N-1:0]    start_i = '0;
   logic [N-1:0]    done_i = '0;
   logic [N-1:0]    viol_i = '0;
   logic [N*RW-1:0] rank_o;
   logic [N-1:0]    head_o;
   logic [N-1:0]    commit_o;
   logic [N-1:0]    restart_o;

   int tests = 0;
   int fails = 0;

   int mh;
   int ms [N];
   logic [N-1:0] mc;
   logic [N-1:0] mr;

   always #4 clk = ~clk;

   spec_thread_sequencer #(.NCORES(N)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_i(done_i),
      .viol_i(viol_i), .rank_o(rank_o), .head_o(head_o),
      .commit_o(commit_o), .restart_o(restart_o)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic model_step(input logic [N-1:0] s, input logic [N-1:0] d, input logic [N-1:0] v);
      int  rk [N];
      int  minr = 99;
      bit  grant;
      for (int c = 0; c < N; c++) rk[c] = (c - mh + N) % N;
      grant = (ms[mh] == 2);
      for (int c = 0; c < N; c++)
         if (v[c] && c != mh && ms[c] != 0 && rk[c] < minr) minr = rk[c];
      mr = '0;
      for (int c = 0; c < N; c++) if (minr != 99 && rk[c] >= minr) mr[c] = 1'b1;
      mc = '0;
      if (grant) mc[mh] = 1'b1;
      for (int c = 0; c < N; c++) begin
         if ((grant && c == mh) || mr[c]) ms[c] = 0;
         else if (ms[c] == 0 && s[c])      ms[c] = 1;
         else if (ms[c] == 1 && d[c])      ms[c] = 2;
      end
      if (grant) mh = (mh + 1) % N;
   endtask

   task automatic cmp_all();
      logic [N-1:0] eh;
      eh = '0;
      eh[mh] = 1'b1;
      chk(head_o == eh, "R2 head", int'(head_o), int'(eh));
      for (int c = 0; c < N; c++)
         chk(int'(rank_o[c*RW +: RW]) == (c - mh + N) % N, "R2 rank",
             int'(rank_o[c*RW +: RW]), (c - mh + N) % N);
      chk(commit_o == mc, "R3 commit", int'(commit_o), int'(mc));
      chk(restart_o == mr, "R7 restart", int'(restart_o), int'(mr));
   endtask

   task automatic drive(input logic [N-1:0] s, input logic [N-1:0] d, input logic [N-1:0] v);
      start_i = s; done_i = d; viol_i = v;
      @(posedge clk);
      model_step(s, d, v);
      @(negedge clk);
      start_i = '0; done_i = '0; viol_i = '0;
      cmp_all();
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
   endtask

   initial begin
      #(8 * 200000);
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
      $finish;
   end

   initial begin
      mh = 0;
      for (int c = 0; c < N; c++) ms[c] = 0;
      mc = '0; mr = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(head_o == 4'b0001, "R1 head", int'(head_o), 1);
      chk(rank_o == 8'hE4, "R1 rank", int'(rank_o), 'hE4);
      chk(commit_o == '0 && restart_o == '0, "R1 pulses", int'({commit_o, restart_o}), 0);

      drive(4'hF, '0, '0);
      // R4: non-head finish waits
      drive('0, 4'b0100, '0);
      drive('0, '0, '0);
      drive('0, '0, '0);
      chk(commit_o == '0, "R4 early finish held", int'(commit_o), 0);
      // R3: head finishes, commits two edges later
      drive('0, 4'b0001, '0);
      chk(commit_o == '0, "R3 no commit yet", int'(commit_o), 0);
      drive('0, '0, '0);
      chk(commit_o == 4'b0001, "R3 commit", int'(commit_o), 1);
      chk(head_o == 4'b0010, "R6 head moved", int'(head_o), 2);
      chk(rank_o[1:0] == 2'd3, "R6 youngest", int'(rank_o[1:0]), 3);
      drive('0, '0, '0);
      chk(commit_o == '0, "R3 single pulse", int'(commit_o), 0);
      drive('0, 4'b0010, '0);
      drive('0, '0, '0);
      chk(commit_o == 4'b0010, "R3 commit core1", int'(commit_o), 2);
      drive('0, '0, '0);
      chk(commit_o == 4'b0100, "R4 cascade", int'(commit_o), 4);

      // R8: two violators, oldest wins (head = core3)
      drive(4'b0111, '0, '0);
      drive('0, '0, 4'b0011);
      chk(restart_o == 4'b0111, "R8 oldest violator", int'(restart_o), 7);
      drive('0, '0, 4'b1000);
      chk(restart_o == '0, "R9 head violation", int'(restart_o), 0);
      drive('0, '0, 4'b0001);
      chk(restart_o == '0, "R9 waiting violation", int'(restart_o), 0);

      // R10 / R11: done while waiting ignored
      drive('0, 4'b0001, '0);
      drive(4'b0111, '0, '0);
      drive('0, 4'b1000, '0);
      drive('0, '0, '0);
      chk(commit_o == 4'b1000, "R10 head commit", int'(commit_o), 8);
      drive('0, '0, '0);
      drive('0, '0, '0);
      chk(commit_o == '0, "R10 stale done ignored", int'(commit_o), 0);
      drive('0, 4'b0001, '0);
      drive('0, '0, '0);
      chk(commit_o == 4'b0001, "R11 done after start", int'(commit_o), 1);

      // R12: commit and violation on same edge (head = core1)
      drive(4'b1001, '0, '0);
      drive('0, 4'b0010, '0);
      drive('0, '0, 4'b0100);
      chk(commit_o == 4'b0010, "R12 commit kept", int'(commit_o), 2);
      chk(restart_o == 4'b1101, "R12 squash old ranks", int'(restart_o), 'hD);

      // random sweep against the model
      for (int i = 0; i < 4000; i++) begin
         logic [N-1:0] s, d, v;
         s = N'($urandom);
         d = N'($urandom) & N'($urandom);
         v = ($urandom % 6 == 0) ? N'($urandom) : '0;
         drive(s, d, v);
      end

      summary();
      $finish;
   end

endmodule